// File: doc/BRIEF.md
# Serial FPGA configuration sequencer

This block loads a target FPGA over its slave-serial configuration port. On a start pulse it asserts the program line and waits for the target to pull INIT low. It then releases program and waits for INIT to return high. After that it takes configuration bytes from an upstream valid/ready stream and sends them out one bit at a time, most significant bit first, with its own clock and data lines. When the byte flagged as last has been sent, it waits for the target to raise DONE.

Each wait phase is timed with a divided tick, nominally one millisecond, and has a limit in ticks. The run ends with a one-cycle report pulse that carries a 2-bit status: success, or one of three timeouts that say which handshake step failed. The target's INIT and DONE lines are asynchronous to the system clock and pass through a two-flop synchroniser. Header parsing and decompression belong to an upstream block; this block only serialises the bytes it is given.

Top module: `serial_cfg_seq`

## Requirements
- R1: Out of reset and while idle, program is inactive, the configuration clock and data are both 1, and busy, the report pulse, the byte ready and status_o are all 0.
- R2: A start pulse sampled while idle raises busy and asserts program on the next cycle. A start pulse while busy has no effect.
- R3: In the INIT-fall phase a tick divider restarts on entry and produces a tick every TICK_CLKS cycles. INIT, delayed by two synchroniser flops, is examined only at each tick. If it is seen low, the block moves on. If TIMEOUT_TICKS ticks pass without it, the run ends with status 1.
- R4: In the next phase program is inactive and the tick divider restarts. Seeing the synchronised INIT high at a tick moves the block to streaming. If TIMEOUT_TICKS ticks pass without it, the run ends with status 2.
- R5: byte_ready_o is 1 only in the streaming phase while no byte is being sent. A byte is taken at a clock edge where ready and valid are both 1. Bytes offered in any other phase are not taken and never appear on the data line.
- R6: Each bit takes four steps of STEP_CLKS cycles each (at least 1): clock 0 with data 1, then clock 0 with data equal to the bit, then clock 1 with data equal to the bit, then clock 1 with data 1. Data therefore never changes on a rising edge of the configuration clock.
- R7: Bytes are sent most significant bit first. A byte occupies 32×STEP_CLKS cycles starting at the edge that accepts it. Ready returns in the cycle after its last step.
- R8: After the byte flagged last has been sent, a DONE-wait phase with a restarted divider begins. Seeing the synchronised DONE high at a tick gives status 0. If TIMEOUT_TICKS ticks pass without it, the status is 3.
- R9: The run ends with report_o high for exactly one cycle, the cycle after the deciding tick. status_o carries the result only in that cycle and reads 0 otherwise. Busy stays high through the report cycle and falls right after it.
- R10: With PROG_ACTIVE_HIGH = 0 the asserted program level is 0. With 1 it is 1, and the program output is the exact inverse of the default build under the same stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| byte_data_i | input | BYTE_W | Configuration byte |
| byte_valid_i | input | 1 | Byte offer valid |
| byte_last_i | input | 1 | Marks the final byte of the image |
| byte_ready_o | output | 1 | Byte accepted at this edge if valid |
| target_init_i | input | 1 | Target INIT line (asynchronous) |
| target_done_i | input | 1 | Target DONE line (asynchronous) |
| prog_o | output | 1 | Program line to target, polarity by parameter |
| cclk_o | output | 1 | Configuration clock to target |
| dout_o | output | 1 | Configuration data to target |
| busy_o | output | 1 | High from start until after the report pulse |
| report_o | output | 1 | One-cycle end-of-run pulse |
| status_o | output | 2 | 0 ok, 1 INIT did not fall, 2 INIT did not rise, 3 DONE did not rise; valid with report_o |

## Verification
Program and busy respond one cycle after a start is sampled. A change on INIT or DONE takes effect at the first tick that falls at least two clocks after it, and the report pulse follows that tick by one cycle. Each accepted byte drives the data line for exactly 32×STEP_CLKS cycles from its accepting edge. The bench advances a behavioural model that has these latencies built in. At every falling clock edge it compares all outputs against the model, so each result is checked in the cycle it is due and in no other. Bits captured on rising configuration-clock edges and the final status of each run are checked on top of that.

// File: rtl/cfg_seq_pkg.sv
// Shared types for the serial configuration sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_WAIT_LO,
        SEQ_WAIT_HI,
        SEQ_STREAM,
        SEQ_WAIT_DONE,
        SEQ_REPORT
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_NO_FALL = 2'd1,
        RES_NO_RISE = 2'd2,
        RES_NO_DONE = 2'd3
    } seq_result_e;

endpackage

// File: rtl/cfg_sync2.sv
// Two-flop synchroniser, one independent chain per bit.
// Assumes: each input bit is a slow level; no bus coherence is needed between bits.
module cfg_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar g = 0; g < W; g++) begin : g_chain
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[g];
                stab_q <= meta_q;
            end
        end

        assign sync_o[g] = stab_q;

        p_two_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |=> (sync_o[g] == $past(async_i[g], 2)));
    end

endmodule

// File: rtl/cfg_tick_timer.sv
// Phase timer: divides the clock into ticks and counts the ticks of one wait phase.
// Assumes: restart_i pulses on every phase change; run_i is high only in wait phases.
module cfg_tick_timer #(
    parameter int TICK_CLKS     = 100000,
    parameter int TIMEOUT_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic tick_o,
    output logic expire_o
);

    localparam int TCLK = (TICK_CLKS < 1) ? 1 : TICK_CLKS;
    localparam int TMO  = (TIMEOUT_TICKS < 1) ? 1 : TIMEOUT_TICKS;
    localparam int CW   = (TCLK > 1) ? $clog2(TCLK) : 1;
    localparam int KW   = (TMO > 1) ? $clog2(TMO) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TCLK - 1);
    localparam logic [KW-1:0] TKS_LAST = KW'(TMO - 1);

    logic [CW-1:0] cnt_q;
    logic [KW-1:0] tks_q;

    assign tick_o   = run_i && (cnt_q == CNT_LAST);
    assign expire_o = tick_o && (tks_q == TKS_LAST);

    // Clock divider and per-phase tick counter, cleared on each phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || !run_i) begin
            cnt_q <= '0;
            tks_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            if (tks_q != TKS_LAST) begin
                tks_q <= tks_q + 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    if (TCLK > 1) begin : g_spacing
        p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_o && run_i && !restart_i) |=> !tick_o);
    end

endmodule

// File: rtl/cfg_bit_pump.sv
// Sends one byte MSB first as four timed steps per bit on clock/data lines.
// Assumes: load_i only while idle_o is high; lines rest at 1/1 when idle.
module cfg_bit_pump #(
    parameter int BYTE_W    = 8,
    parameter int STEP_CLKS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              idle_o,
    output logic              fin_o,
    output logic              cclk_o,
    output logic              dout_o
);

    localparam int STEPS = (STEP_CLKS < 1) ? 1 : STEP_CLKS;
    localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int BW    = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [SW-1:0] STEP_LAST = SW'(STEPS - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(BYTE_W - 1);

    logic              active_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BW-1:0]     bit_q;
    logic [1:0]        phase_q;
    logic [SW-1:0]     scnt_q;
    logic              step_end;
    logic              bit_end;

    assign step_end = (scnt_q == STEP_LAST);
    assign bit_end  = step_end && (phase_q == 2'd3);
    assign fin_o    = active_q && bit_end && (bit_q == BIT_LAST);
    assign idle_o   = !active_q;

    // Step/bit sequencing and the MSB-first shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sh_q     <= '0;
            bit_q    <= '0;
            phase_q  <= 2'd0;
            scnt_q   <= '0;
        end else if (load_i) begin
            active_q <= 1'b1;
            sh_q     <= data_i;
            bit_q    <= '0;
            phase_q  <= 2'd0;
            scnt_q   <= '0;
        end else if (active_q) begin
            if (step_end) begin
                scnt_q  <= '0;
                phase_q <= phase_q + 2'd1;
                if (bit_end) begin
                    sh_q  <= sh_q << 1;
                    bit_q <= bit_q + 1'b1;
                    if (bit_q == BIT_LAST) begin
                        active_q <= 1'b0;
                    end
                end
            end else begin
                scnt_q <= scnt_q + 1'b1;
            end
        end
    end

    // Line levels per step: 0/1, 0/b, 1/b, 1/1 (clock/data).
    always_comb begin
        cclk_o = !active_q || phase_q[1];
        dout_o = 1'b1;
        if (active_q && (phase_q == 2'd1 || phase_q == 2'd2)) begin
            dout_o = sh_q[BYTE_W-1];
        end
    end

    p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_o) |-> $stable(dout_o));

    p_load_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !active_q);

endmodule

// File: rtl/serial_cfg_seq.sv
// Top: program/INIT/DONE handshake sequencer around a serial bit pump.
// Assumes: target lines are asynchronous; bytes arrive already decompressed.
module serial_cfg_seq
    import cfg_seq_pkg::*;
#(
    parameter int TICK_CLKS        = 100000,
    parameter int TIMEOUT_TICKS    = 4,
    parameter int STEP_CLKS        = 1,
    parameter int PROG_ACTIVE_HIGH = 0,
    parameter int BYTE_W           = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] byte_data_i,
    input  logic              byte_valid_i,
    input  logic              byte_last_i,
    output logic              byte_ready_o,
    input  logic              target_init_i,
    input  logic              target_done_i,
    output logic              prog_o,
    output logic              cclk_o,
    output logic              dout_o,
    output logic              busy_o,
    output logic              report_o,
    output logic [1:0]        status_o
);

    seq_state_e  state_q, state_d;
    seq_result_e result_q, result_d;
    logic        last_q;
    logic        init_s, done_s;
    logic        tick, expire, restart, run;
    logic        pump_idle, pump_fin, accept;
    logic        prog_on;

    cfg_sync2 #(.W(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({target_done_i, target_init_i}),
        .sync_o  ({done_s, init_s})
    );

    assign run = (state_q == SEQ_WAIT_LO) || (state_q == SEQ_WAIT_HI) ||
                 (state_q == SEQ_WAIT_DONE);

    cfg_tick_timer #(.TICK_CLKS(TICK_CLKS), .TIMEOUT_TICKS(TIMEOUT_TICKS)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .run_i     (run),
        .tick_o    (tick),
        .expire_o  (expire)
    );

    assign byte_ready_o = (state_q == SEQ_STREAM) && pump_idle;
    assign accept       = byte_ready_o && byte_valid_i;

    cfg_bit_pump #(.BYTE_W(BYTE_W), .STEP_CLKS(STEP_CLKS)) pump_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .data_i (byte_data_i),
        .idle_o (pump_idle),
        .fin_o  (pump_fin),
        .cclk_o (cclk_o),
        .dout_o (dout_o)
    );

    // Next-state and result selection for the handshake phases.
    always_comb begin
        state_d  = state_q;
        result_d = result_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_i) begin
                    state_d = SEQ_WAIT_LO;
                end
            end
            SEQ_WAIT_LO: begin
                if (tick && !init_s) begin
                    state_d = SEQ_WAIT_HI;
                end else if (expire) begin
                    state_d  = SEQ_REPORT;
                    result_d = RES_NO_FALL;
                end
            end
            SEQ_WAIT_HI: begin
                if (tick && init_s) begin
                    state_d = SEQ_STREAM;
                end else if (expire) begin
                    state_d  = SEQ_REPORT;
                    result_d = RES_NO_RISE;
                end
            end
            SEQ_STREAM: begin
                if (pump_fin && last_q) begin
                    state_d = SEQ_WAIT_DONE;
                end
            end
            SEQ_WAIT_DONE: begin
                if (tick && done_s) begin
                    state_d  = SEQ_REPORT;
                    result_d = RES_OK;
                end else if (expire) begin
                    state_d  = SEQ_REPORT;
                    result_d = RES_NO_DONE;
                end
            end
            SEQ_REPORT: begin
                state_d = SEQ_IDLE;
            end
            default: begin
                state_d = SEQ_IDLE;
            end
        endcase
    end

    assign restart = (state_d != state_q);

    // State, result and end-of-image flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            result_q <= RES_OK;
            last_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            result_q <= result_d;
            if (accept) begin
                last_q <= byte_last_i;
            end
        end
    end

    // Output decode from the registered state.
    always_comb begin
        prog_on  = (state_q == SEQ_WAIT_LO);
        prog_o   = (PROG_ACTIVE_HIGH != 0) ? prog_on : !prog_on;
        busy_o   = (state_q != SEQ_IDLE);
        report_o = (state_q == SEQ_REPORT);
        status_o = report_o ? result_q : RES_OK;
    end

    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!prog_on && cclk_o && dout_o && !byte_ready_o));

    p_start_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && prog_on));

    p_ready_lines_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (cclk_o && dout_o && !prog_on));

    p_ok_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (report_o && status_o == RES_OK) |-> $past(done_s));

    p_report_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        report_o |=> !report_o);

    p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(report_o));

endmodule

// File: tb/serial_cfg_seq_tb_top.sv
module serial_cfg_seq_tb_top;

    localparam int TICK = 16;
    localparam int TMO  = 4;
    localparam int STEP = 2;
    localparam int BCYC = 32 * STEP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] bdata = 8'h00;
    logic       bvalid = 1'b0;
    logic       blast = 1'b0;
    logic       tinit = 1'b1;
    logic       tdone = 1'b0;

    logic       ready, prog, cclk, dout, busy, rep;
    logic [1:0] status;
    logic       ready_h, prog_h, cclk_h, dout_h, busy_h, rep_h;
    logic [1:0] status_h;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;

    always #2 clk = ~clk;

    serial_cfg_seq #(.TICK_CLKS(TICK), .TIMEOUT_TICKS(TMO), .STEP_CLKS(STEP),
                     .PROG_ACTIVE_HIGH(0), .BYTE_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .byte_data_i(bdata),
        .byte_valid_i(bvalid), .byte_last_i(blast), .byte_ready_o(ready),
        .target_init_i(tinit), .target_done_i(tdone), .prog_o(prog),
        .cclk_o(cclk), .dout_o(dout), .busy_o(busy), .report_o(rep),
        .status_o(status));

    serial_cfg_seq #(.TICK_CLKS(TICK), .TIMEOUT_TICKS(TMO), .STEP_CLKS(STEP),
                     .PROG_ACTIVE_HIGH(1), .BYTE_W(8)) dut_hi_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .byte_data_i(bdata),
        .byte_valid_i(bvalid), .byte_last_i(blast), .byte_ready_o(ready_h),
        .target_init_i(tinit), .target_done_i(tdone), .prog_o(prog_h),
        .cclk_o(cclk_h), .dout_o(dout_h), .busy_o(busy_h), .report_o(rep_h),
        .status_o(status_h));

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    int       m_ph, m_tc, m_tk, m_st, m_cyc;
    bit [7:0] m_byte;
    bit       m_last, m_i1, m_i2, m_d1, m_d2;

    always @(posedge clk) begin
        bit ci, cd, ok;
        if (!rst_n) begin
            m_ph = 0; m_tc = 0; m_tk = 0; m_st = 0; m_cyc = -1; m_last = 0;
            m_i1 = 0; m_i2 = 0; m_d1 = 0; m_d2 = 0;
        end else begin
            ci = m_i2; cd = m_d2;
            m_i2 = m_i1; m_i1 = tinit;
            m_d2 = m_d1; m_d1 = tdone;
            if (m_ph == 0) begin
                if (start) begin m_ph = 1; m_tc = 0; m_tk = 0; end
            end else if (m_ph == 1 || m_ph == 2 || m_ph == 4) begin
                if (m_tc == TICK - 1) begin
                    m_tc = 0;
                    ok = (m_ph == 1) ? !ci : ((m_ph == 2) ? ci : cd);
                    if (ok) begin
                        m_tk = 0;
                        if (m_ph == 1) m_ph = 2;
                        else if (m_ph == 2) begin m_ph = 3; m_cyc = -1; end
                        else begin m_st = 0; m_ph = 5; end
                    end else if (m_tk == TMO - 1) begin
                        m_st = (m_ph == 1) ? 1 : ((m_ph == 2) ? 2 : 3);
                        m_ph = 5;
                    end else begin
                        m_tk++;
                    end
                end else begin
                    m_tc++;
                end
            end else if (m_ph == 3) begin
                if (m_cyc < 0) begin
                    if (bvalid) begin m_byte = bdata; m_last = blast; m_cyc = 0; end
                end else if (m_cyc == BCYC - 1) begin
                    m_cyc = -1;
                    if (m_last) begin m_ph = 4; m_tc = 0; m_tk = 0; end
                end else begin
                    m_cyc++;
                end
            end else begin
                m_ph = 0;
            end
        end
    end

    // Compare every output against the model at each falling edge.
    always @(negedge clk) begin
        int stp;
        bit ec, ed, b;
        if (cmp_on) begin
            ec = 1; ed = 1;
            if (m_ph == 3 && m_cyc >= 0) begin
                stp = (m_cyc % (4 * STEP)) / STEP;
                b   = m_byte[7 - m_cyc / (4 * STEP)];
                ec  = (stp >= 2);
                ed  = (stp == 1 || stp == 2) ? b : 1'b1;
            end
            check("R2", "prog_o", int'(prog), (m_ph == 1) ? 0 : 1);
            check("R6", "cclk_o", int'(cclk), int'(ec));
            check("R6", "dout_o", int'(dout), int'(ed));
            check("R5", "byte_ready_o", int'(ready), (m_ph == 3 && m_cyc < 0) ? 1 : 0);
            check("R9", "busy_o", int'(busy), (m_ph != 0) ? 1 : 0);
            check("R9", "report_o", int'(rep), (m_ph == 5) ? 1 : 0);
            check("R9", "status_o", int'(status), (m_ph == 5) ? m_st : 0);
            check("R10", "prog_o polarity", int'(prog_h), int'(!prog));
        end
    end

    // Bits seen by the target on rising configuration-clock edges.
    bit cap_q[$];
    initial begin
        forever begin
            @(posedge cclk);
            if (busy === 1'b1) cap_q.push_back(dout);
        end
    end

    task automatic expect_bits(input string tag, input bit [7:0] bytes[$]);
        int k;
        check(tag, "captured bit count", cap_q.size(), 8 * bytes.size());
        k = 0;
        foreach (bytes[i]) begin
            for (int j = 7; j >= 0; j--) begin
                if (k < cap_q.size()) check(tag, "captured bit", int'(cap_q[k]), int'(bytes[i][j]));
                k++;
            end
        end
        cap_q.delete();
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic send_byte(input bit [7:0] d, input bit l);
        @(posedge clk); #1;
        bdata = d; blast = l; bvalid = 1'b1;
        forever begin
            @(negedge clk);
            if (ready) break;
        end
        @(posedge clk); #1;
        bvalid = 1'b0; blast = 1'b0;
    endtask

    task automatic wait_report(input string tag, input int exp);
        int guard;
        guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if (rep || guard > 3000) break;
        end
        check(tag, "final status", int'(status), exp);
    endtask

    task automatic handshake_ok();
        cycles(10);
        tinit = 1'b0;
        forever begin
            @(negedge clk);
            if (prog) break;
        end
        cycles(6);
        tinit = 1'b1;
    endtask

    initial begin
        bit [7:0] img[$];
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "prog_o idle", int'(prog), 1);
        check("R1", "cclk_o idle", int'(cclk), 1);
        check("R1", "dout_o idle", int'(dout), 1);
        check("R1", "busy_o idle", int'(busy), 0);
        check("R1", "ready idle", int'(ready), 0);
        check("R1", "status idle", int'(status), 0);
        cycles(4);

        // Full run: ignored early bytes, second start ignored, gap between bytes.
        cap_q.delete();
        pulse_start();
        bdata = 8'hFF; bvalid = 1'b1;
        cycles(4);
        bvalid = 1'b0;
        handshake_ok();
        cycles(2);
        pulse_start();
        send_byte(8'hA5, 1'b0);
        cycles(BCYC + 9);
        send_byte(8'h3C, 1'b0);
        send_byte(8'h81, 1'b1);
        cycles(BCYC + 20);
        tdone = 1'b1;
        wait_report("R8", 0);
        img = '{8'hA5, 8'h3C, 8'h81};
        expect_bits("R7", img);
        tdone = 1'b0;
        cycles(8);

        // INIT never falls.
        pulse_start();
        wait_report("R3", 1);
        check("R3", "no bits sent", cap_q.size(), 0);
        cycles(8);

        // INIT falls but never rises.
        pulse_start();
        cycles(5);
        tinit = 1'b0;
        wait_report("R4", 2);
        tinit = 1'b1;
        cycles(8);

        // DONE never rises after a single-byte image.
        cap_q.delete();
        pulse_start();
        handshake_ok();
        send_byte(8'h5A, 1'b1);
        wait_report("R8", 3);
        img = '{8'h5A};
        expect_bits("R7", img);
        cycles(4);
        check("R1", "busy_o after run", int'(busy), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule